// File: doc/BRIEF.md
# Memory Error Capture and Access Limit Guard

This block sits on the memory controller side of a chip. It watches the results of memory reads, and each read result carries an error class decided upstream. When a read is reported as uncorrectable, it logs the event. When a read is reported as correctable and the low-priority check enable is on, it logs that event too. Logging an event stores the raw 64-bit double word, its 8-bit check byte and the failing address in read-only capture registers. It also sets a sticky status flag. An uncorrectable event drives a high-priority machine-check output. A correctable event drives a low-priority one.

The block also guards every access that is not an I/O access. It compares the access address against a programmable upper limit that works at 4 MiB granularity. An access above the limit is held back, so it is not forwarded, and a sticky address-error flag is set. A small register port writes the control and limit registers, reads every register, and clears status flags by writing ones.

Top module: `memerr_guard`

## Requirements
- R1: After reset, control reads 0, limit reads 0xFFC00000, status reads 0, every capture register reads 0, and both machine-check outputs are low.
- R2: A read result with `rd_ue` high sets status bit 1 on the next clock. While that bit is set, `mchk_hi` is high.
- R3: A read result with `rd_ce` high (and `rd_ue` low) sets status bit 0 only when control bit 16 is 1. With bit 16 at 0, the flag is not set and nothing is captured. `mchk_lo` follows status bit 0.
- R4: A logged event captures the data as two words: offset 3 holds bits 63:32 and offset 4 holds bits 31:0. It captures the check byte in bits 7:0 of offset 5 and the address at offset 6. The most recent logged event overwrites earlier captures.
- R5: Register offsets are 0 control, 1 limit, 2 status, 3 to 6 capture, and 7 reads 0. The limit keeps only address bits 31:22, and its low 22 bits always read 0.
- R6: A non-I/O access whose address bits 31:22 are greater than the limit bits is not forwarded. It sets status bit 2 on the next clock. An access equal to the limit is forwarded.
- R7: An access with `acc_io` high is always forwarded and never sets status bit 2.
- R8: Status is write-one-to-clear, and bits written 0 are kept. When a flag is cleared and set in the same cycle, the set wins.
- R9: A read result with both `rd_ce` and `rd_ue` high is treated as uncorrectable only, so status bit 0 is not set.
- R10: Writes to the status-capture offsets 3 to 6 do not change their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| acc_valid | input | 1 | Access request valid |
| acc_io | input | 1 | Access targets I/O space (bypasses limit) |
| acc_addr | input | 32 | Access address |
| fwd_valid | output | 1 | Access forwarded to memory |
| fwd_addr | output | 32 | Forwarded access address |
| rd_valid | input | 1 | Read result valid |
| rd_addr | input | 32 | Address of the read result |
| rd_data | input | 64 | Raw read double word |
| rd_check | input | 8 | Raw check byte |
| rd_ce | input | 1 | Correctable error reported |
| rd_ue | input | 1 | Uncorrectable error reported |
| mchk_hi | output | 1 | High-priority machine check (status bit 1) |
| mchk_lo | output | 1 | Low-priority machine check (status bit 0) |

## Verification
Two things can act on a status flag in the same cycle. One is the register port writing a one to clear it. The other is the event source setting it, which is a read-error report for bits 0 and 1 or a rejected access for bit 2. The bench drives the clearing write and the setting event on the same falling edge. It then reads status after the next rising edge and expects the flag to still be set. A clear with no competing event is checked separately, to show that the clear works on its own.

// File: rtl/memerr_guard.sv
module memerr_guard #(
  parameter int AW       = 32,
  parameter int LIM_LSB  = 22,
  parameter int CKW      = 8,
  parameter int LPEN_BIT = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           acc_valid,
  input  logic           acc_io,
  input  logic [AW-1:0]  acc_addr,
  output logic           fwd_valid,
  output logic [AW-1:0]  fwd_addr,
  input  logic           rd_valid,
  input  logic [AW-1:0]  rd_addr,
  input  logic [63:0]    rd_data,
  input  logic [CKW-1:0] rd_check,
  input  logic           rd_ce,
  input  logic           rd_ue,
  output logic           mchk_hi,
  output logic           mchk_lo
);
  localparam int LW = AW - LIM_LSB;
  localparam logic [2:0] A_CTRL = 3'd0, A_LIM = 3'd1, A_STAT = 3'd2,
                         A_DHI = 3'd3, A_DLO = 3'd4, A_CK = 3'd5, A_EADR = 3'd6;

  logic           lp_en;
  logic [LW-1:0]  lim_q;
  logic [2:0]     st_q;
  logic [31:0]    cap_hi, cap_lo;
  logic [CKW-1:0] cap_ck;
  logic [AW-1:0]  cap_addr;

  logic over, addr_err, ue_ev, ce_ev, log_ev;
  logic [2:0] clr, st_set;

  assign over     = acc_addr[AW-1:LIM_LSB] > lim_q;
  assign addr_err = acc_valid & ~acc_io & over;
  assign fwd_valid = acc_valid & ~addr_err;
  assign fwd_addr  = acc_addr;

  assign ue_ev  = rd_valid & rd_ue;
  assign ce_ev  = rd_valid & rd_ce & ~rd_ue & lp_en;
  assign log_ev = ue_ev | ce_ev;

  assign clr    = (reg_wr && reg_addr == A_STAT) ? reg_wdata[2:0] : 3'b000;
  assign st_set = {addr_err, ue_ev, ce_ev};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_en <= 1'b0;
      lim_q <= '1;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) lp_en <= reg_wdata[LPEN_BIT];
      if (reg_addr == A_LIM)  lim_q <= reg_wdata[AW-1:LIM_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr) | st_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_hi   <= '0;
      cap_lo   <= '0;
      cap_ck   <= '0;
      cap_addr <= '0;
    end else if (log_ev) begin
      cap_hi   <= rd_data[63:32];
      cap_lo   <= rd_data[31:0];
      cap_ck   <= rd_check;
      cap_addr <= rd_addr;
    end
  end

  assign mchk_hi = st_q[1];
  assign mchk_lo = st_q[0];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[LPEN_BIT] = lp_en;
      A_LIM:  reg_rdata = 32'({lim_q, {LIM_LSB{1'b0}}});
      A_STAT: reg_rdata[2:0] = st_q;
      A_DHI:  reg_rdata = cap_hi;
      A_DLO:  reg_rdata = cap_lo;
      A_CK:   reg_rdata = 32'(cap_ck);
      A_EADR: reg_rdata = 32'(cap_addr);
      default: reg_rdata = '0;
    endcase
  end
endmodule

module memerr_guard_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          acc_valid,
  input logic          acc_io,
  input logic          fwd_valid,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ce,
  input logic          rd_ue,
  input logic          lp_en,
  input logic [2:0]    st_q,
  input logic [AW-1:0] cap_addr,
  input logic          mchk_hi
);
  assert_ue_mchk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ue) |=> mchk_hi);

  assert_ce_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ce && !rd_ue && !lp_en && !st_q[0]) |=> !st_q[0]);

  assert_capture_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ue) |=> cap_addr == $past(rd_addr));

  assert_block_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !fwd_valid) |=> st_q[2]);

  assert_io_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_io) |-> fwd_valid);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[1] && !(reg_wr && reg_addr == 3'd2 && reg_wdata[1])) |=> st_q[1]);
endmodule

bind memerr_guard memerr_guard_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_io(acc_io),
  .fwd_valid(fwd_valid), .rd_valid(rd_valid), .rd_addr(rd_addr),
  .rd_ce(rd_ce), .rd_ue(rd_ue), .lp_en(lp_en), .st_q(st_q),
  .cap_addr(cap_addr), .mchk_hi(mchk_hi)
);

// File: tb/memerr_guard_tb.sv
module memerr_guard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic acc_valid = 1'b0, acc_io = 1'b0;
  logic [31:0] acc_addr = '0, fwd_addr;
  logic fwd_valid;
  logic rd_valid = 1'b0, rd_ce = 1'b0, rd_ue = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [63:0] rd_data = '0;
  logic [7:0] rd_check = '0;
  logic mchk_hi, mchk_lo;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  memerr_guard dut_i (.*);

  // {limit[9:0], addr[31:22], io, expect_fwd}
  localparam logic [21:0] VEC [6] = '{
    {10'h3FF, 10'h3FF, 1'b0, 1'b1},
    {10'h010, 10'h010, 1'b0, 1'b1},
    {10'h010, 10'h011, 1'b0, 1'b0},
    {10'h010, 10'h011, 1'b1, 1'b1},
    {10'h000, 10'h000, 1'b0, 1'b1},
    {10'h000, 10'h3FF, 1'b0, 1'b0}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ev(logic [31:0] a, logic [63:0] d, logic [7:0] c, logic ce, logic ue);
    @(negedge clk); rd_valid = 1; rd_addr = a; rd_data = d; rd_check = c; rd_ce = ce; rd_ue = ue;
    @(negedge clk); rd_valid = 0; rd_ce = 0; rd_ue = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 limit", v, 32'hFFC00000);
    rd(3'd2, v); chk("R1 status", v, 0);
    for (int a = 3; a <= 7; a++) begin rd(3'(a), v); chk("R1 capture", v, 0); end
    chk("R1 mchk", {mchk_hi, mchk_lo}, 0);

    for (int i = 0; i < 6; i++) begin
      wr(3'd1, {VEC[i][21:12], 22'h3FFFFF});
      rd(3'd1, v); chk("R5 limit low bits", v, {VEC[i][21:12], 22'h0});
      acc_addr = {VEC[i][11:2], 22'h2ABCDE}; acc_io = VEC[i][1]; acc_valid = 1; #1;
      chk(VEC[i][1] ? "R7 io forward" : "R6 forward", fwd_valid, VEC[i][0]);
      @(negedge clk); acc_valid = 0;
      rd(3'd2, v); chk(VEC[i][1] ? "R7 no flag" : "R6 flag", v[2], !VEC[i][0]);
      wr(3'd2, 32'h4);
      rd(3'd2, v); chk("R8 clear bit2", v[2], 0);
    end

    ev(32'h1000_0040, 64'h1111_2222_3333_4444, 8'h5A, 1, 0);
    rd(3'd2, v); chk("R3 ce disabled no flag", v, 0);
    rd(3'd6, v); chk("R3 ce disabled no capture", v, 0);

    wr(3'd0, 32'h0001_0000);
    rd(3'd0, v); chk("R5 ctrl bit16", v, 32'h0001_0000);
    ev(32'h1000_0080, 64'hAAAA_BBBB_CCCC_DDDD, 8'hC3, 1, 0);
    rd(3'd2, v); chk("R3 ce flag", v, 1);
    chk("R3 mchk_lo", mchk_lo, 1);
    rd(3'd3, v); chk("R4 hi word", v, 32'hAAAA_BBBB);
    rd(3'd4, v); chk("R4 lo word", v, 32'hCCCC_DDDD);

    ev(32'h2000_0100, 64'h0123_4567_89AB_CDEF, 8'h3C, 0, 1);
    rd(3'd2, v); chk("R2 ue flag", v, 3);
    chk("R2 mchk_hi", mchk_hi, 1);
    rd(3'd3, v); chk("R4 last wins hi", v, 32'h0123_4567);
    rd(3'd4, v); chk("R4 last wins lo", v, 32'h89AB_CDEF);
    rd(3'd5, v); chk("R4 check byte", v, 32'h3C);
    rd(3'd6, v); chk("R4 address", v, 32'h2000_0100);
    rd(3'd7, v); chk("R5 offset7 zero", v, 0);

    wr(3'd2, 32'h1);
    rd(3'd2, v); chk("R8 clear only bit0", v, 2);
    chk("R3 mchk_lo low", mchk_lo, 0);

    for (int a = 3; a <= 6; a++) begin
      wr(3'(a), 32'hDEAD_BEEF);
    end
    rd(3'd3, v); chk("R10 hi kept", v, 32'h0123_4567);
    rd(3'd6, v); chk("R10 addr kept", v, 32'h2000_0100);

    @(negedge clk);
    reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h2;
    rd_valid = 1; rd_ue = 1; rd_addr = 32'h3000_0000;
    @(negedge clk); reg_wr = 0; rd_valid = 0; rd_ue = 0;
    rd(3'd2, v); chk("R8 set wins over clear", v[1], 1);

    wr(3'd2, 32'h7);
    rd(3'd2, v); chk("R8 clear all", v, 0);
    chk("R2 mchk_hi low", mchk_hi, 0);

    ev(32'h4000_0000, 64'h5, 8'h1, 1, 1);
    rd(3'd2, v); chk("R9 both is ue only", v, 2);

    wr(3'd1, 32'h0);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h4;
    acc_valid = 1; acc_io = 0; acc_addr = 32'h0800_0000;
    @(negedge clk); reg_wr = 0; acc_valid = 0;
    rd(3'd2, v); chk("R8 addr set wins", v[2], 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule